// File: doc/BRIEF.md
# Two-Slot Event Capture Controller

This block is the per-channel digital control for a pair of analog sample-and-hold slots that are used as a two-entry FIFO. An asynchronous discriminator trigger is brought into the 40 MHz control clock domain and turned into a single capture pulse. The slot that is open at that moment is closed, which means its held sample is frozen. At the same edge, the current coarse timestamp is stored in a register that belongs to that slot.

The write side and the read side are two separate four-state machines. The write machine fills the slots in strict ring order, 0, 1, 0, 1. It opens the next slot only once that slot has been freed. The read machine presents the oldest written slot together with its timestamp. When the downstream converter or readout sequencer is done with that slot, it pulses a done request, and the slot is erased and freed.

Capture never pauses while a slot is being converted or read out. The only time a trigger is refused is when both slots hold data; that trigger is dropped and a sticky overflow flag is set. The block also contains its own Gray-coded coarse time counter, which advances once every `TICK_DIV` control clocks. It also drives a channel hit flag.

Top module: `esm_top`

## Requirements
- R1: After reset, `sel_o` is 2'b01 (slot 0 open) and `hold_o`, `erase_o`, `rd_valid_o`, `hit_o`, `ovf_o` and `ts_o` are all zero.
- R2: Every rising edge of `trig_i` gives exactly one capture, at the third clock edge that samples `trig_i` high. A trigger held high for many cycles still captures only once.
- R3: Slots are filled in ring order 0, 1, 0, 1. `sel_o` (bit n is slot n) is one-hot on the next slot in the ring while that slot is free, and 2'b00 otherwise. A capture sets the matching `hold_o` bit.
- R4: A captured slot stores the `ts_o` value present at its capture edge. `rd_ts_o` shows that value while the slot is presented to the reader.
- R5: `rd_valid_o` rises one cycle after the oldest unread slot is written, with `rd_slot_o` naming that slot. A `rd_done_i` pulse while `rd_valid_o` is high clears that slot's `hold_o` bit and produces a one-cycle `erase_o` pulse on that slot's bit in the next cycle. A `rd_done_i` pulse while `rd_valid_o` is low has no effect.
- R6: A capture that arrives while both slots are written is dropped and leaves both stored timestamps unchanged. `ovf_o` is set and stays high until reset.
- R7: `hit_o` is high exactly when at least one slot is written.
- R8: `ts_o` is a Gray code. It changes only once every `TICK_DIV` clocks, by a single bit, and its binary value steps up by one.
- R9: A slot that is free is accepted for capture while the other slot is still waiting to be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Asynchronous delayed trigger from the discriminator |
| rd_done_i | input | 1 | Reader has finished with the presented slot; frees it |
| sel_o | output | 2 | One-hot slot open for capture (column select) |
| hold_o | output | 2 | Per-slot hold: slot contains a captured sample |
| erase_o | output | 2 | One-cycle erase pulse for a freed slot |
| rd_valid_o | output | 1 | A written slot is presented to the reader |
| rd_slot_o | output | 1 | Index of the presented slot |
| rd_ts_o | output | TS_W | Gray timestamp of the presented slot |
| ts_o | output | TS_W | Free-running Gray coarse time |
| hit_o | output | 1 | At least one slot is written |
| ovf_o | output | 1 | Sticky flag: a trigger was dropped because both slots were full |

## Verification
The bench fills both slots and then fires a third trigger. A design that closes no slot would still overwrite a stored timestamp, or would leave the overflow flag low. It frees slot 0 while slot 1 is pending and triggers again: a design whose write pointer restarts at the free slot rather than following the ring, or that stalls capture during readout, returns the slots in the wrong order or misses the event. It holds a trigger high for many cycles, which catches a level-sensitive synchroniser that captures repeatedly. It pulses the done request with nothing to read; a design that acts on it would erase a slot or shift the read order.

// File: rtl/esm_pkg.sv
package esm_pkg;
  localparam int unsigned NSLOT = 2;

  typedef enum logic [1:0] {
    W_OPEN0 = 2'd0,
    W_HELD0 = 2'd1,
    W_OPEN1 = 2'd2,
    W_HELD1 = 2'd3
  } wr_st_e;

  typedef enum logic [1:0] {
    R_WAIT0 = 2'd0,
    R_RDY0  = 2'd1,
    R_WAIT1 = 2'd2,
    R_RDY1  = 2'd3
  } rd_st_e;
endpackage

// File: rtl/esm_trig_sync.sv
module esm_trig_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pulse_o = s2_q & ~s3_q;

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R2
endmodule

// File: rtl/esm_gray_ts.sv
module esm_gray_ts #(
  parameter int unsigned TS_W     = 24,
  parameter int unsigned TICK_DIV = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] gray_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0]   pre_q;
  logic [TS_W-1:0] bin_q, bin_nxt, gray_q;
  logic            tick;

  assign tick    = (pre_q == PW'(TICK_DIV - 1));
  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      bin_q  <= '0;
      gray_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  assign gray_o = gray_q;

  AST_GRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ($countones(gray_q ^ $past(gray_q)) == 1)); // R8
  AST_GRAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(gray_q)); // R8
endmodule

// File: rtl/esm_wr_ctrl.sv
module esm_wr_ctrl
  import esm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [NSLOT-1:0] free_i,
  output logic [NSLOT-1:0] sel_o,
  output logic [NSLOT-1:0] store_o,
  output logic [NSLOT-1:0] written_o,
  output logic             ovf_o
);
  wr_st_e           st_q, st_d;
  logic [NSLOT-1:0] written_q;
  logic             ovf_q;

  // open column: the ring target, only once it has been freed
  always_comb begin
    unique case (st_q)
      W_OPEN0: sel_o = 2'b01;
      W_HELD0: sel_o = written_q[1] ? 2'b00 : 2'b10;
      W_OPEN1: sel_o = 2'b10;
      W_HELD1: sel_o = written_q[0] ? 2'b00 : 2'b01;
      default: sel_o = 2'b00;
    endcase
  end

  assign store_o = sel_o & {NSLOT{cap_i}};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      W_OPEN0: if (cap_i) st_d = W_HELD0;
      W_HELD0: if (!written_q[1]) st_d = cap_i ? W_HELD1 : W_OPEN1;
      W_OPEN1: if (cap_i) st_d = W_HELD1;
      W_HELD1: if (!written_q[0]) st_d = cap_i ? W_HELD0 : W_OPEN0;
      default: st_d = W_OPEN0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= W_OPEN0;
      written_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      written_q <= (written_q | store_o) & ~free_i;
      ovf_q     <= ovf_q | (cap_i & ~|sel_o);
    end
  end

  assign written_o = written_q;
  assign ovf_o     = ovf_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R3
  AST_STORE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |store_o |-> ((store_o & written_q) == '0)); // R3
  AST_FULL_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&written_q) |-> (sel_o == '0)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R6
endmodule

// File: rtl/esm_rd_ctrl.sv
module esm_rd_ctrl
  import esm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSLOT-1:0] written_i,
  input  logic             done_i,
  output logic             valid_o,
  output logic             slot_o,
  output logic [NSLOT-1:0] free_o
);
  rd_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    free_o = '0;
    unique case (st_q)
      R_WAIT0: if (written_i[0]) st_d = R_RDY0;
      R_RDY0: if (done_i) begin
        st_d   = R_WAIT1;
        free_o = 2'b01;
      end
      R_WAIT1: if (written_i[1]) st_d = R_RDY1;
      R_RDY1: if (done_i) begin
        st_d   = R_WAIT0;
        free_o = 2'b10;
      end
      default: st_d = R_WAIT0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= R_WAIT0;
    else         st_q <= st_d;
  end

  assign valid_o = (st_q == R_RDY0) || (st_q == R_RDY1);
  assign slot_o  = (st_q == R_WAIT1) || (st_q == R_RDY1);

  AST_VALID_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> written_i[slot_o]); // R5
  AST_IDLE_NO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (free_o == '0)); // R5
endmodule

// File: rtl/esm_top.sv
module esm_top
  import esm_pkg::*;
#(
  parameter int unsigned TS_W     = 24,
  parameter int unsigned TICK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             rd_done_i,
  output logic [NSLOT-1:0] sel_o,
  output logic [NSLOT-1:0] hold_o,
  output logic [NSLOT-1:0] erase_o,
  output logic             rd_valid_o,
  output logic             rd_slot_o,
  output logic [TS_W-1:0]  rd_ts_o,
  output logic [TS_W-1:0]  ts_o,
  output logic             hit_o,
  output logic             ovf_o
);
  logic             cap;
  logic [NSLOT-1:0] store, written, free;
  logic [TS_W-1:0]  gray;
  logic [TS_W-1:0]  ts_q [NSLOT];
  logic [NSLOT-1:0] erase_q;

  esm_trig_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .pulse_o (cap)
  );

  esm_gray_ts #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_ts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gray_o (gray)
  );

  esm_wr_ctrl u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .free_i    (free),
    .sel_o     (sel_o),
    .store_o   (store),
    .written_o (written),
    .ovf_o     (ovf_o)
  );

  esm_rd_ctrl u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .written_i (written),
    .done_i    (rd_done_i),
    .valid_o   (rd_valid_o),
    .slot_o    (rd_slot_o),
    .free_o    (free)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ts_q[s] <= '0;
      else if (store[s]) ts_q[s] <= gray;
    end

    AST_TS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      written[s] && !free[s] |=> $stable(ts_q[s])); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) erase_q <= '0;
    else         erase_q <= free;
  end

  assign hold_o  = written;
  assign erase_o = erase_q;
  assign rd_ts_o = ts_q[rd_slot_o];
  assign ts_o    = gray;
  assign hit_o   = |written;

  AST_HIT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |store |=> hit_o); // R7
endmodule

// File: tb/tb_esm_top.sv
module tb_esm_top;
  localparam int unsigned TS_W     = 24;
  localparam int unsigned TICK_DIV = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trig = 1'b0;
  logic            rd_done = 1'b0;
  logic [1:0]      sel, hold, erase;
  logic            rd_valid, rd_slot, hit, ovf;
  logic [TS_W-1:0] rd_ts, ts;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // scoreboard: {slot, timestamp}
  logic [TS_W:0] sb_q[$];
  int       cnt = 0;
  bit       wp = 1'b0;
  bit       exp_ovf = 1'b0;
  logic [1:0] exp_hold = 2'b00;

  always #2.5 clk = ~clk;

  esm_top #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .trig_i     (trig),
    .rd_done_i  (rd_done),
    .sel_o      (sel),
    .hold_o     (hold),
    .erase_o    (erase),
    .rd_valid_o (rd_valid),
    .rd_slot_o  (rd_slot),
    .rd_ts_o    (rd_ts),
    .ts_o       (ts),
    .hit_o      (hit),
    .ovf_o      (ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TS_W-1:0] g2b(input logic [TS_W-1:0] g);
    logic [TS_W-1:0] b;
    b[TS_W-1] = g[TS_W-1];
    for (int i = TS_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [1:0] exp_sel();
    return (cnt < 2) ? (wp ? 2'b10 : 2'b01) : 2'b00;
  endfunction

  // driver: one trigger, held high for 'len' cycles after capture
  task automatic fire(input int len);
    logic [TS_W-1:0] ets;
    @(negedge clk) trig = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) ets = ts;            // value latched at next edge
    if (cnt < 2) begin
      sb_q.push_back({wp, ets});
      exp_hold[wp] = 1'b1;
      wp = ~wp;
      cnt++;
    end else begin
      exp_ovf = 1'b1;
    end
    @(negedge clk);
    chk("R3 hold after capture", 32'(hold), 32'(exp_hold));
    chk("R6 overflow flag", 32'(ovf), 32'(exp_ovf));
    for (int i = 0; i < len; i++) @(negedge clk);
    trig = 1'b0;
    chk("R2 single capture", 32'(hold), 32'(exp_hold));
    @(negedge clk);
    @(negedge clk);
    chk("R3 open slot", 32'(sel), 32'(exp_sel()));
    chk("R7 hit flag", 32'(hit), 32'(cnt != 0));
  endtask

  // monitor: pop oldest and compare against presented slot
  task automatic pop_read();
    logic [TS_W:0] e;
    @(negedge clk);
    @(negedge clk);
    chk("R5 read valid", 32'(rd_valid), 32'd1);
    e = sb_q.pop_front();
    chk("R5 read slot", 32'(rd_slot), 32'(e[TS_W]));
    chk("R4 stored timestamp", 32'(rd_ts), 32'(e[TS_W-1:0]));
    rd_done = 1'b1;
    @(posedge clk);
    @(negedge clk) rd_done = 1'b0;
    chk("R5 erase pulse", 32'(erase), 32'(2'b01 << e[TS_W]));
    exp_hold[e[TS_W]] = 1'b0;
    cnt--;
    chk("R5 slot freed", 32'(hold), 32'(exp_hold));
    chk("R7 hit flag", 32'(hit), 32'(cnt != 0));
    @(negedge clk);
    chk("R5 erase one cycle", 32'(erase), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [TS_W-1:0] g0, g1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sel", 32'(sel), 32'h1);
    chk("R1 hold", 32'(hold), 32'h0);
    chk("R1 erase", 32'(erase), 32'h0);
    chk("R1 valid", 32'(rd_valid), 32'h0);
    chk("R1 hit", 32'(hit), 32'h0);
    chk("R1 ovf", 32'(ovf), 32'h0);

    // Gray time base
    for (int k = 0; k < 3; k++) begin
      g0 = ts;
      repeat (TICK_DIV) @(negedge clk);
      g1 = ts;
      chk("R8 binary step", 32'(g2b(g1) - g2b(g0)), 32'd1);
      chk("R8 one bit flips", $countones(g1 ^ g0), 32'd1);
    end

    // single events, ring order across empty FIFO
    fire(2);
    pop_read();
    fire(2);
    chk("R3 ring wraps to slot 0", 32'(sel), 32'h1);
    pop_read();

    // fill both, then overflow
    fire(3);
    repeat (5) @(negedge clk);
    fire(1);
    chk("R3 no open slot when full", 32'(sel), 32'h0);
    repeat (7) @(negedge clk);
    fire(2);
    chk("R6 hold unchanged on drop", 32'(hold), 32'h3);

    // capture during readout
    pop_read();
    repeat (3) @(negedge clk);
    fire(2);
    pop_read();
    pop_read();
    chk("R6 overflow sticky", 32'(ovf), 32'd1);

    // done request with nothing presented
    @(negedge clk) rd_done = 1'b1;
    @(negedge clk) rd_done = 1'b0;
    chk("R5 spurious done no erase", 32'(erase), 32'h0);
    chk("R5 spurious done no valid", 32'(rd_valid), 32'h0);
    @(negedge clk);
    chk("R5 spurious done no erase later", 32'(erase), 32'h0);

    // long trigger: one capture only, then ring continues
    fire(12);
    repeat (4) @(negedge clk);
    fire(2);
    pop_read();
    pop_read();
    chk("R9 scoreboard drained", sb_q.size(), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule